// File: doc/BRIEF.md
# Dual-Mode Converter Serial Output Register

This block sits on the digital output side of a successive-approximation converter. A working register captures each new conversion result. At the end of every conversion the result moves into a shift register, which a host then reads one bit at a time, most significant bit first. All logic runs on one system clock. The conversion-phase input `busy_i` is high while idle and low while a conversion runs. The host's serial clock `ext_sclk_i` is sampled as a level on the system clock.

There are two clocking modes. In internal mode the block makes its own data clock. It shifts out the result of conversion n while conversion n+1 runs, and the rising edge of that clock marks each valid bit. In external mode the host supplies the data clock. The shift register is refilled only at the end of a conversion, so the host can read a result after its conversion or during the next one. An active-low chip select gates the outputs in both modes. In external mode it also gates the host clock. The mode select is taken in only while the block is idle.

Top module: `adc_sout`

## Requirements
- R1: `busy_i` high means idle and low means converting. On the cycle `busy_i` rises, the value held in the working register (last loaded by `res_vld_i`/`res_i`) is copied into the shift register. The copy is unconditional in internal mode and subject to R7 in external mode.
- R2: In internal mode (`ext_mode_i`=0), a falling edge of `busy_i` starts exactly WIDTH pulses on `dclk_o`. `data_o` carries the previous result MSB first, each bit steady while `dclk_o` is high and valid at its rising edge.
- R3: In internal mode, `data_o` and `dclk_o` are low whenever no transfer is running, including after reset.
- R4: In internal mode with `cs_ni` high, the transfer still runs internally but `data_o` and `dclk_o` stay low, so that result is lost. The next conversion's result is delivered normally.
- R5: In external mode (`ext_mode_i`=1), each rising edge of `ext_sclk_i` with `cs_ni` low drives the next bit, MSB first, onto `data_o`. The bit stays until the following rising edge, so it can be sampled on the falling edge.
- R6: In external mode, every clock after the last stored bit shifts out 0.
- R7: In external mode, if `ext_sclk_i` is high and `cs_ni` is low when `busy_i` rises, the shift register keeps its previous contents and the new result is dropped. If `cs_ni` is high at that moment, the load happens.
- R8: In external mode with `cs_ni` high, `ext_sclk_i` edges do not shift and `data_o` is low.
- R9: In external mode, a result loaded at the end of one conversion stays readable throughout the next conversion.
- R10: `ext_mode_i` is taken in only when `busy_i` is high and no internal transfer is running. A change during a conversion does not affect that conversion's transfer.
- R11: In external mode, `dclk_o` stays low.
- R12: With WIDTH=12, the register holds 12 bits. `data_o` is 0 from the 13th external clock onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_mode_i | input | 1 | 1 = host-supplied data clock, 0 = internally generated clock |
| cs_ni | input | 1 | Chip select, active low |
| ext_sclk_i | input | 1 | Host data clock (external mode) |
| busy_i | input | 1 | Conversion phase: low while converting |
| res_vld_i | input | 1 | Loads `res_i` into the working register |
| res_i | input | WIDTH | New conversion result |
| data_o | output | 1 | Serial data, MSB first |
| dclk_o | output | 1 | Internally generated data clock |

## Verification
Internal mode is tried with distinct words across back-to-back conversions. This separates a correct one-conversion delay from a same-conversion or stale delivery. Chip select is held high for a whole conversion, which shows whether the lost result is the transferred one and not the newly loaded one. Mode changes in mid-conversion show the mode is taken in only while idle. In external mode, the bench reads after a conversion, reads during the next one, reads with the clock held high across the end of conversion (with chip select low and high), and clocks while deselected. These cases separate the conditional load from an unconditional one and the gated clock from an ungated one. Over-length reads on a 16-bit and a 12-bit instance expose the zero fill.

// File: rtl/adc_sout_pkg.sv
package adc_sout_pkg;
  typedef enum logic {
    PH_LOW  = 1'b0,
    PH_HIGH = 1'b1
  } dclk_phase_e;
endpackage

// File: rtl/adc_sout_dly.sv
module adc_sout_dly #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= RST_VAL;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/adc_sout_shreg.sv
module adc_sout_shreg #(
  parameter int WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [WIDTH-1:0] load_val_i,
  input  logic             shift_i,
  output logic [WIDTH-1:0] sr_o
);
  logic [WIDTH-1:0] sr_d;

  // zero fill from the LSB end; load wins over shift
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if (i == 0) begin : g_lsb
      assign sr_d[i] = load_i ? load_val_i[i] : (shift_i ? 1'b0 : sr_o[i]);
    end else begin : g_up
      assign sr_d[i] = load_i ? load_val_i[i] : (shift_i ? sr_o[i-1] : sr_o[i]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_o <= '0;
    else         sr_o <= sr_d;
  end
endmodule

// File: rtl/adc_sout_intclk.sv
module adc_sout_intclk
  import adc_sout_pkg::*;
#(
  parameter int WIDTH    = 16,
  parameter int HALF_DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic shift_o,
  output logic done_o,
  output logic dclk_o,
  output logic active_o
);
  localparam int CW = (HALF_DIV > 2) ? $clog2(HALF_DIV) : 1;
  localparam int BW = $clog2(WIDTH + 1);

  logic          active_q;
  dclk_phase_e   phase_q;
  logic [CW-1:0] cnt_q;
  logic [BW-1:0] bits_q;
  logic          tick;
  logic          last;

  assign tick     = active_q && (cnt_q == CW'(HALF_DIV - 1));
  assign last     = (bits_q == BW'(WIDTH - 1));
  assign shift_o  = start_i || (tick && phase_q == PH_HIGH && !last);
  assign done_o   = tick && phase_q == PH_HIGH && last;
  assign dclk_o   = active_q && phase_q == PH_HIGH;
  assign active_o = active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      phase_q  <= PH_LOW;
      cnt_q    <= '0;
      bits_q   <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      phase_q  <= PH_LOW;
      cnt_q    <= '0;
      bits_q   <= '0;
    end else if (active_q) begin
      if (tick) begin
        cnt_q <= '0;
        if (phase_q == PH_LOW) begin
          phase_q <= PH_HIGH;
        end else begin
          phase_q <= PH_LOW;
          bits_q  <= bits_q + BW'(1);
          if (last) active_q <= 1'b0;
        end
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end
endmodule

// File: rtl/adc_sout.sv
module adc_sout
  import adc_sout_pkg::*;
#(
  parameter int WIDTH    = 16,
  parameter int HALF_DIV = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ext_mode_i,
  input  logic             cs_ni,
  input  logic             ext_sclk_i,
  input  logic             busy_i,
  input  logic             res_vld_i,
  input  logic [WIDTH-1:0] res_i,
  output logic             data_o,
  output logic             dclk_o
);
  logic             busy_q;
  logic             sclk_q;
  logic             mode_q;
  logic             out_q;
  logic [WIDTH-1:0] work_q;
  logic [WIDTH-1:0] sr_q;

  logic busy_rise, busy_fall, ext_rise;
  logic idle, mode_chg, ext_hold, load, shift, clr;
  logic int_start, int_shift, int_done, int_dclk, int_active;

  adc_sout_dly #(.RST_VAL(1'b1)) u_busy_dly (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (busy_i),
    .q_o   (busy_q)
  );

  adc_sout_dly #(.RST_VAL(1'b0)) u_sclk_dly (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ext_sclk_i),
    .q_o   (sclk_q)
  );

  assign busy_rise = busy_i && !busy_q;
  assign busy_fall = !busy_i && busy_q;
  assign ext_rise  = ext_sclk_i && !sclk_q;

  assign idle      = busy_i && busy_q && !int_active;
  assign mode_chg  = idle && (ext_mode_i != mode_q);
  // host clock high and selected at end of conversion: keep old contents
  assign ext_hold  = mode_q && ext_sclk_i && !cs_ni;
  assign load      = busy_rise && !ext_hold;
  assign int_start = busy_fall && !mode_q && !int_active;
  assign shift     = mode_q ? (ext_rise && !cs_ni) : int_shift;
  assign clr       = int_done || mode_chg;

  adc_sout_intclk #(
    .WIDTH   (WIDTH),
    .HALF_DIV(HALF_DIV)
  ) u_intclk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (int_start),
    .shift_o (int_shift),
    .done_o  (int_done),
    .dclk_o  (int_dclk),
    .active_o(int_active)
  );

  adc_sout_shreg #(.WIDTH(WIDTH)) u_shreg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .load_val_i(work_q),
    .shift_i   (shift),
    .sr_o      (sr_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        work_q <= '0;
    else if (res_vld_i) work_q <= res_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mode_q <= 1'b0;
    else if (idle) mode_q <= ext_mode_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           out_q <= 1'b0;
    else if (shift)        out_q <= sr_q[WIDTH-1];
    else if (load || clr)  out_q <= 1'b0;
  end

  assign data_o = out_q && !cs_ni;
  assign dclk_o = int_dclk && !cs_ni;
endmodule

// File: rtl/adc_sout_chk.sv
module adc_sout_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             busy_i,
  input logic             busy_q,
  input logic             cs_ni,
  input logic             ext_sclk_i,
  input logic             sclk_q,
  input logic             mode_q,
  input logic             int_active,
  input logic [WIDTH-1:0] work_q,
  input logic [WIDTH-1:0] sr_q,
  input logic             data_o,
  input logic             dclk_o
);
  AST_LOAD_INT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !busy_q && !mode_q) |=> (sr_q == $past(work_q))); // R1

  AST_LOAD_EXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !busy_q && mode_q && (!ext_sclk_i || cs_ni)) |=> (sr_q == $past(work_q))); // R1

  AST_SKIP_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !busy_q && mode_q && ext_sclk_i && sclk_q && !cs_ni) |=> $stable(sr_q)); // R7

  AST_INT_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_q && !int_active) |-> (!data_o && !dclk_o)); // R3

  AST_EXT_NO_DCLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q |-> !dclk_o); // R11

  AST_MODE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q || int_active) |=> $stable(mode_q)); // R10
endmodule

bind adc_sout adc_sout_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .busy_i    (busy_i),
  .busy_q    (busy_q),
  .cs_ni     (cs_ni),
  .ext_sclk_i(ext_sclk_i),
  .sclk_q    (sclk_q),
  .mode_q    (mode_q),
  .int_active(int_active),
  .work_q    (work_q),
  .sr_q      (sr_q),
  .data_o    (data_o),
  .dclk_o    (dclk_o)
);

// File: tb/tb_adc_sout.sv
module tb_adc_sout;
  localparam int CONV = 90;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ext_mode = 1'b0;
  logic        cs_n = 1'b0;
  logic        sclk = 1'b0;
  logic        busy = 1'b1;
  logic        res_vld = 1'b0;
  logic [15:0] res = '0;
  logic        data, dclk, data12, dclk12;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  adc_sout #(.WIDTH(16), .HALF_DIV(2)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .ext_mode_i(ext_mode), .cs_ni(cs_n),
    .ext_sclk_i(sclk), .busy_i(busy), .res_vld_i(res_vld), .res_i(res),
    .data_o(data), .dclk_o(dclk)
  );

  adc_sout #(.WIDTH(12), .HALF_DIV(2)) dut12 (
    .clk_i(clk), .rst_ni(rst_ni), .ext_mode_i(ext_mode), .cs_ni(cs_n),
    .ext_sclk_i(sclk), .busy_i(busy), .res_vld_i(res_vld), .res_i(res[11:0]),
    .data_o(data12), .dclk_o(dclk12)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one conversion; samples the 16-bit instance every cycle
  task automatic run_conv(input logic [15:0] val, input bit int_chk, input int flip_at,
                          output logic [15:0] word, output int pulses,
                          output bit idle_bad, output bit any_act);
    logic prev = 1'b0;
    word = '0; pulses = 0; idle_bad = 1'b0; any_act = 1'b0;
    @(negedge clk);
    busy = 1'b0;
    for (int i = 1; i < CONV + 10; i++) begin
      @(negedge clk);
      if (dclk && !prev) begin
        pulses++;
        word = {word[14:0], data};
      end
      prev = dclk;
      if (data || dclk) any_act = 1'b1;
      if (int_chk && i >= 68 && (data || dclk)) idle_bad = 1'b1;
      if (i == flip_at) ext_mode = 1'b1;
      if (i == CONV - 5) begin res_vld = 1'b1; res = val; end
      if (i == CONV - 4) res_vld = 1'b0;
      if (i == CONV) busy = 1'b1;
    end
  endtask

  task automatic ext_read(input int n, output logic [31:0] w, output logic [31:0] w12);
    w = '0; w12 = '0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk); sclk = 1'b1;
      @(negedge clk);
      @(negedge clk);
      w   = {w[30:0], data};
      w12 = {w12[30:0], data12};
      sclk = 1'b0;
      @(negedge clk);
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(!data && !dclk, "R3 reset outputs low", {30'b0, data, dclk}, 32'h0);
  endtask

  task automatic t_internal();
    logic [15:0] w; int p; bit ib, aa;
    run_conv(16'hA5C3, 1'b1, -1, w, p, ib, aa);
    run_conv(16'h3C96, 1'b1, -1, w, p, ib, aa);
    check(w == 16'hA5C3, "R2 internal word is previous result", {16'b0, w}, 32'hA5C3);
    check(p == 16, "R2 internal pulse count", p, 16);
    check(!ib, "R3 internal outputs low after transfer", {31'b0, ib}, 32'h0);
  endtask

  task automatic t_int_cs();
    logic [15:0] w; int p; bit ib, aa;
    cs_n = 1'b1;
    run_conv(16'h8001, 1'b1, -1, w, p, ib, aa);
    cs_n = 1'b0;
    check(p == 0, "R4 no pulses while deselected", p, 0);
    check(!aa, "R4 data and clock quiet while deselected", {31'b0, aa}, 32'h0);
    // mode flips mid-conversion: this transfer must still be internal
    run_conv(16'h7E18, 1'b1, 5, w, p, ib, aa);
    check(w == 16'h8001, "R4 next result delivered, deselected one lost", {16'b0, w}, 32'h8001);
    check(p == 16, "R10 mode change ignored during conversion", p, 16);
  endtask

  task automatic t_ext_basic();
    logic [15:0] w; int p; bit ib, aa;
    logic [31:0] r, r12;
    run_conv(16'hC35A, 1'b0, -1, w, p, ib, aa);
    check(p == 0, "R11 no internal clock in external mode", p, 0);
    cs_n = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); sclk = 1'b1;
      @(negedge clk); @(negedge clk);
      if (data) aa = 1'b1;
      sclk = 1'b0;
      @(negedge clk); @(negedge clk);
    end
    check(!aa, "R8 data low while deselected", {31'b0, aa}, 32'h0);
    cs_n = 1'b0;
    @(negedge clk);
    ext_read(20, r, r12);
    check(r == {12'b0, 16'hC35A, 4'b0}, "R5 R6 R8 external read then zero fill", r,
          {12'b0, 16'hC35A, 4'b0});
    check(r12 == {12'b0, 12'h35A, 8'b0}, "R12 12-bit read then zero fill", r12,
          {12'b0, 12'h35A, 8'b0});
  endtask

  task automatic t_ext_next();
    logic [15:0] w; int p; bit ib, aa;
    logic [31:0] r, r12;
    run_conv(16'h1F2E, 1'b0, -1, w, p, ib, aa);
    fork
      run_conv(16'hE4B7, 1'b0, -1, w, p, ib, aa);
      ext_read(16, r, r12);
    join
    check(r == 32'h1F2E, "R9 read during next conversion", r, 32'h1F2E);
    check(r12 == {16'b0, 12'hF2E, 4'b0}, "R9 R12 read during next conversion", r12,
          {16'b0, 12'hF2E, 4'b0});
  endtask

  task automatic t_ext_skip();
    logic [15:0] w; int p; bit ib, aa;
    logic [31:0] r, r12;
    logic b0, b0_12;
    b0 = 1'b0; b0_12 = 1'b0;
    fork
      run_conv(16'h0FF0, 1'b0, -1, w, p, ib, aa);
      begin
        repeat (20) @(negedge clk);
        sclk = 1'b1;
        @(negedge clk); @(negedge clk);
        b0 = data; b0_12 = data12;
        repeat (80) @(negedge clk);
        sclk = 1'b0;
        @(negedge clk); @(negedge clk);
      end
    join
    ext_read(15, r, r12);
    check({b0, r[14:0]} == 16'hE4B7, "R7 load skipped, old word kept",
          {16'b0, b0, r[14:0]}, 32'hE4B7);
    check({b0_12, r12[14:0]} == {12'h4B7, 4'b0}, "R7 R12 load skipped",
          {16'b0, b0_12, r12[14:0]}, {16'b0, 12'h4B7, 4'b0});

    cs_n = 1'b1;
    fork
      run_conv(16'h9669, 1'b0, -1, w, p, ib, aa);
      begin
        repeat (50) @(negedge clk);
        sclk = 1'b1;
        repeat (60) @(negedge clk);
        sclk = 1'b0;
      end
    join
    @(negedge clk); @(negedge clk);
    cs_n = 1'b0;
    @(negedge clk);
    ext_read(16, r, r12);
    check(r == 32'h9669, "R7 load taken when deselected", r, 32'h9669);
    check(r12 == {16'b0, 12'h669, 4'b0}, "R7 R12 load taken when deselected", r12,
          {16'b0, 12'h669, 4'b0});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_internal();
    t_int_cs();
    t_ext_basic();
    t_ext_next();
    t_ext_skip();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule